// File: doc/BRIEF.md
# Buck Regulator Startup and Fault Sequencer

This block is the digital supervisor of a synchronous step-down regulator controller. It takes the outputs of several analog comparators, already reduced to single-bit flags: bias power-good (hysteresis applied upstream), switch node above its threshold, low-side switch conducting, low-side over-current, and feedback undervoltage. It also takes a one-cycle tick from a clock-enable timebase. From these it decides when the PWM may run and what clamp code the soft-start ramp presents to the reference comparison.

After power-good rises, the block first checks that the input supply is present. It sends short periodic high-side probe pulses and waits for the switch node to rise and then fall. Once that is seen, it starts a linear soft-start ramp, one code step per timebase tick, up to a reference code. It then holds the regulating state. An over-current or undervoltage fault stops the PWM for a fixed recovery interval and restarts soft-start from zero. When a fault arrives after the allowed number of such restarts, the block latches off. Only a loss of power-good clears the latch.

All comparator flags pass through two-flop synchronisers. The probe timing, the ramp length, the recovery interval and the restart allowance are parameters. All outputs come straight from flip-flops.

Top module: `buck_start_seq`

## Requirements
- R1: While the synchronised power-good flag is low, `probe_req`, `pwm_en` and `shutdown` are 0 and `ss_code` is 0. The restart count and the input-presence detection are cleared. A power-good loss reaches the outputs within 4 clock cycles.
- R2: After power-good, and until input presence is confirmed, `probe_req` is a periodic pulse. It is high for exactly `PROBE_WIDTH` cycles in every `PROBE_PERIOD` cycles. `pwm_en` stays 0 throughout.
- R3: Input presence is confirmed only after the synchronised switch-node flag has risen and then fallen while probing. A rising edge alone does not end probing.
- R4: On confirmation, probing stops and `pwm_en` goes to 1 with `ss_code` at 0. While in soft-start, `ss_code` rises by exactly 1 for each cycle in which `ramp_tick` is 1.
- R5: `ss_code` stops at `REF_CODE` and never exceeds it. On reaching it the block is regulating, `pwm_en` stays 1, and further ticks do not change `ss_code`.
- R6: An over-current fault is accepted only when `oc_in` and `lo_on_in` are both 1 for two consecutive synchronised samples. A single-sample pulse is ignored, and so is `oc_in` with `lo_on_in` at 0.
- R7: An accepted fault during soft-start or regulation drops `pwm_en` for exactly `HICCUP_CYCLES` cycles. During that interval `ss_code` returns to 0. Soft-start then restarts from 0 with `pwm_en` at 1.
- R8: A synchronised `fbuv_in` of 1 during soft-start or regulation is a fault. It has the same effect and the same counting as an over-current fault.
- R9: A fault that arrives after `MAX_HICCUPS` restarts have already happened sets `shutdown` to 1 and forces `pwm_en`, `probe_req` and `ss_code` to 0. This state holds while power-good stays high. After a power-good loss and return, probing starts again.
- R10: `pwm_en` and `probe_req` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pgood_in | input | 1 | Bias supply power-good comparator flag (asynchronous) |
| sw_hi_in | input | 1 | Switch node above threshold flag (asynchronous) |
| lo_on_in | input | 1 | Low-side switch conducting flag (asynchronous) |
| oc_in | input | 1 | Low-side over-current comparator flag (asynchronous) |
| fbuv_in | input | 1 | Feedback undervoltage comparator flag (asynchronous) |
| ramp_tick | input | 1 | One-cycle soft-start step enable from the timebase |
| probe_req | output | 1 | High-side probe pulse request |
| ss_code | output | SS_W | Soft-start ramp clamp code |
| pwm_en | output | 1 | PWM enable |
| shutdown | output | 1 | Latched fault shutdown flag |

## Verification
The end of probing and the start of soft-start can fall in the same cycle. The switch-node fall that confirms input presence may arrive while a probe pulse is still high, and the PWM enable rises in that same cycle. The bench provokes this by raising and then dropping the switch-node flag inside a single probe pulse. It watches every cycle for the probe request and the PWM enable being high together, and it then checks that the probe request stays low once the PWM enable is up. The same overlap watch runs through the fault restarts and the latch-off.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_PROBE  = 3'd1,
    ST_SOFT   = 3'd2,
    ST_REG    = 3'd3,
    ST_HICCUP = 3'd4,
    ST_LATCH  = 3'd5
  } seq_state_t;

  localparam int unsigned NUM_FLAGS = 5;
  localparam int unsigned IX_PGOOD  = 0;
  localparam int unsigned IX_SWHI   = 1;
  localparam int unsigned IX_LOON   = 2;
  localparam int unsigned IX_OC     = 3;
  localparam int unsigned IX_FBUV   = 4;

endpackage

// File: rtl/bseq_sync.sv
module bseq_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/bseq_probe_timer.sv
module bseq_probe_timer #(
  parameter int unsigned PERIOD = 10000,
  parameter int unsigned WIDTH  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pulse
);

  localparam int unsigned TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [TW-1:0] LAST  = TW'(PERIOD - 1);
  localparam logic [TW-1:0] HIGHN = TW'(WIDTH);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
      pulse <= (cnt < HIGHN);
    end
  end

endmodule

// File: rtl/bseq_ramp.sv
module bseq_ramp #(
  parameter int unsigned SS_W     = 8,
  parameter int unsigned REF_CODE = 200
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            step,
  output logic [SS_W-1:0] code,
  output logic            at_ref
);

  localparam logic [SS_W-1:0] TOP = SS_W'(REF_CODE);

  always_ff @(posedge clk) begin
    if (rst || clr)             code <= '0;
    else if (step && code < TOP) code <= code + 1'b1;
  end

  assign at_ref = (code == TOP);

endmodule

// File: rtl/bseq_fault_qual.sv
module bseq_fault_qual (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic oc_s,
  input  logic lo_s,
  input  logic uv_s,
  output logic fault_q
);

  logic ocl_now;
  logic ocl_prev;

  assign ocl_now = oc_s & lo_s;

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      ocl_prev <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      ocl_prev <= ocl_now;
      fault_q  <= (ocl_now && ocl_prev) || uv_s;
    end
  end

endmodule

// File: rtl/buck_start_seq.sv
module buck_start_seq
  import buck_seq_pkg::*;
#(
  parameter int unsigned PROBE_PERIOD  = 10000,
  parameter int unsigned PROBE_WIDTH   = 100,
  parameter int unsigned SS_W          = 8,
  parameter int unsigned REF_CODE      = 200,
  parameter int unsigned HICCUP_CYCLES = 1024,
  parameter int unsigned MAX_HICCUPS   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pgood_in,
  input  logic            sw_hi_in,
  input  logic            lo_on_in,
  input  logic            oc_in,
  input  logic            fbuv_in,
  input  logic            ramp_tick,
  output logic            probe_req,
  output logic [SS_W-1:0] ss_code,
  output logic            pwm_en,
  output logic            shutdown
);

  localparam int unsigned HW = $clog2(HICCUP_CYCLES + 1);
  localparam int unsigned CW = $clog2(MAX_HICCUPS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HICCUP_CYCLES - 1);
  localparam logic [CW-1:0] HIC_MAX   = CW'(MAX_HICCUPS);

  logic [NUM_FLAGS-1:0] flags_s;
  logic pgood_s, sw_s, lo_s, oc_s, uv_s;

  bseq_sync #(.WIDTH(NUM_FLAGS), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({fbuv_in, oc_in, lo_on_in, sw_hi_in, pgood_in}),
    .sync_out (flags_s)
  );

  assign pgood_s = flags_s[IX_PGOOD];
  assign sw_s    = flags_s[IX_SWHI];
  assign lo_s    = flags_s[IX_LOON];
  assign oc_s    = flags_s[IX_OC];
  assign uv_s    = flags_s[IX_FBUV];

  seq_state_t state_q, state_d;
  logic          sw_d, rise_seen;
  logic [HW-1:0] hold_cnt;
  logic [CW-1:0] hic_cnt;
  logic          fault_q, at_ref, confirm, armed;

  assign armed   = (state_q == ST_SOFT) || (state_q == ST_REG);
  assign confirm = (state_q == ST_PROBE) && rise_seen && sw_d && !sw_s;

  bseq_fault_qual u_fault (
    .clk     (clk),
    .rst     (rst),
    .arm     (armed),
    .oc_s    (oc_s),
    .lo_s    (lo_s),
    .uv_s    (uv_s),
    .fault_q (fault_q)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:    state_d = ST_PROBE;
      ST_PROBE:  if (confirm) state_d = ST_SOFT;
      ST_SOFT, ST_REG: begin
        if (fault_q)     state_d = (hic_cnt == HIC_MAX) ? ST_LATCH : ST_HICCUP;
        else if (at_ref) state_d = ST_REG;
      end
      ST_HICCUP: if (hold_cnt == HOLD_LAST) state_d = ST_SOFT;
      ST_LATCH:  state_d = ST_LATCH;
      default:   state_d = ST_OFF;
    endcase
    if (!pgood_s) state_d = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      sw_d      <= 1'b0;
      rise_seen <= 1'b0;
      hold_cnt  <= '0;
      hic_cnt   <= '0;
    end else begin
      state_q <= state_d;
      sw_d    <= sw_s;
      if (state_q != ST_PROBE || !pgood_s) rise_seen <= 1'b0;
      else if (sw_s && !sw_d)               rise_seen <= 1'b1;
      if (state_q != ST_HICCUP) hold_cnt <= '0;
      else                      hold_cnt <= hold_cnt + 1'b1;
      if (state_d == ST_OFF)                                hic_cnt <= '0;
      else if (state_d == ST_HICCUP && state_q != ST_HICCUP) hic_cnt <= hic_cnt + 1'b1;
    end
  end

  bseq_ramp #(.SS_W(SS_W), .REF_CODE(REF_CODE)) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .clr    (!(state_d == ST_SOFT || state_d == ST_REG)),
    .step   (ramp_tick && state_q == ST_SOFT),
    .code   (ss_code),
    .at_ref (at_ref)
  );

  bseq_probe_timer #(.PERIOD(PROBE_PERIOD), .WIDTH(PROBE_WIDTH)) u_probe (
    .clk   (clk),
    .rst   (rst),
    .en    (state_d == ST_PROBE),
    .pulse (probe_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_en   <= 1'b0;
      shutdown <= 1'b0;
    end else begin
      pwm_en   <= (state_d == ST_SOFT) || (state_d == ST_REG);
      shutdown <= (state_d == ST_LATCH);
    end
  end

endmodule

// File: rtl/buck_start_seq_chk.sv
module buck_start_seq_chk #(
  parameter int unsigned SS_W     = 8,
  parameter int unsigned REF_CODE = 200
) (
  input logic            clk,
  input logic            rst,
  input logic            pgood_s,
  input logic            probe_req,
  input logic            pwm_en,
  input logic            shutdown,
  input logic [SS_W-1:0] ss_code
);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    !(pwm_en && probe_req));

  assert_pgood_clear_R1: assert property (@(posedge clk) disable iff (rst)
    !pgood_s |=> (!pwm_en && !probe_req && !shutdown && ss_code == '0));

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (shutdown && pgood_s) |=> shutdown);

  assert_latch_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> (!pwm_en && !probe_req && ss_code == '0));

  assert_ramp_bound_R5: assert property (@(posedge clk) disable iff (rst)
    ss_code <= SS_W'(REF_CODE));

  assert_ramp_step_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ss_code == $past(ss_code) || ss_code == $past(ss_code) + 1'b1 || ss_code == '0));

endmodule

bind buck_start_seq buck_start_seq_chk #(.SS_W(SS_W), .REF_CODE(REF_CODE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pgood_s   (pgood_s),
  .probe_req (probe_req),
  .pwm_en    (pwm_en),
  .shutdown  (shutdown),
  .ss_code   (ss_code)
);

// File: tb/tb_buck_start_seq.sv
`timescale 1ns/1ps
module tb_buck_start_seq;

  localparam int PER = 1000;
  localparam int WID = 10;
  localparam int REF = 40;
  localparam int HIC = 16;
  localparam int MAXH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pgood_in = 0, sw_hi_in = 0, lo_on_in = 0, oc_in = 0, fbuv_in = 0, ramp_tick = 0;
  logic probe_req, pwm_en, shutdown;
  logic [7:0] ss_code;

  int n_chk = 0, n_bad = 0, overlap = 0, probe_rises = 0, pwm_falls = 0;
  logic probe_prev = 0, pwm_prev = 0;

  always #5 clk = ~clk;

  buck_start_seq #(.PROBE_PERIOD(PER), .PROBE_WIDTH(WID), .SS_W(8), .REF_CODE(REF),
                   .HICCUP_CYCLES(HIC), .MAX_HICCUPS(MAXH)) dut (
    .clk(clk), .rst(rst), .pgood_in(pgood_in), .sw_hi_in(sw_hi_in), .lo_on_in(lo_on_in),
    .oc_in(oc_in), .fbuv_in(fbuv_in), .ramp_tick(ramp_tick), .probe_req(probe_req),
    .ss_code(ss_code), .pwm_en(pwm_en), .shutdown(shutdown));

  always @(negedge clk) begin
    if (pwm_en && probe_req) overlap++;
    if (probe_req && !probe_prev) probe_rises++;
    if (!pwm_en && pwm_prev) pwm_falls++;
    probe_prev <= probe_req;
    pwm_prev   <= pwm_en;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ramp_tick = 1'b1;
      @(negedge clk) ramp_tick = 1'b0;
      step(2);
    end
  endtask

  task automatic wait_probe_rise(output int ok);
    ok = 0;
    for (int i = 0; i < 3 * PER; i++) begin
      @(negedge clk);
      if (probe_req && !probe_prev) begin ok = 1; break; end
    end
  endtask

  task automatic measure_low(output int dur);
    dur = 0;
    for (int i = 0; i < 100; i++) begin
      if (!pwm_en) break;
      @(negedge clk);
    end
    for (int i = 0; i < 500; i++) begin
      if (pwm_en) break;
      dur++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    step(3);
    chk("R1", "probe_req in reset/no pgood", probe_req, 0);
    chk("R1", "pwm_en in reset/no pgood", pwm_en, 0);
    chk("R1", "shutdown in reset/no pgood", shutdown, 0);
    chk("R1", "ss_code in reset/no pgood", ss_code, 0);
    @(negedge clk) rst = 1'b0;
    step(20);
    chk("R1", "probe_req with pgood low", probe_req, 0);
  endtask

  task automatic t_probe();
    int ok, w, p;
    @(negedge clk) pgood_in = 1'b1;
    wait_probe_rise(ok);
    chk("R2", "first probe pulse seen", ok, 1);
    w = 0;
    while (probe_req && w < 2 * PER) begin w++; @(negedge clk); end
    chk("R2", "probe width cycles", w, WID);
    p = w;
    while (!probe_req && p < 3 * PER) begin p++; @(negedge clk); end
    chk("R2", "probe period cycles", p, PER);
    chk("R2", "pwm_en while probing", pwm_en, 0);
  endtask

  task automatic t_presence();
    int ok;
    wait_probe_rise(ok);
    @(negedge clk) sw_hi_in = 1'b1;
    step(30);
    chk("R3", "rise alone keeps pwm off", pwm_en, 0);
    wait_probe_rise(ok);
    chk("R3", "probing continues after rise only", ok, 1);
    sw_hi_in = 1'b0;
    step(12);
    chk("R3", "pwm_en after rise+fall", pwm_en, 1);
    chk("R4", "ss_code at soft-start entry", ss_code, 0);
    step(2 * PER);
    chk("R4", "no probe pulse after confirm", probe_req, 0);
  endtask

  task automatic t_softstart();
    ticks(5);
    chk("R4", "ss_code after 5 ticks", ss_code, 5);
    ticks(REF - 6);
    chk("R4", "ss_code one below ref", ss_code, REF - 1);
    ticks(1);
    chk("R5", "ss_code at ref", ss_code, REF);
    ticks(10);
    chk("R5", "ss_code held after extra ticks", ss_code, REF);
    chk("R5", "pwm_en while regulating", pwm_en, 1);
  endtask

  task automatic t_oc_rejected();
    int f0;
    f0 = pwm_falls;
    @(negedge clk) begin lo_on_in = 1'b0; oc_in = 1'b1; end
    step(20);
    @(negedge clk) oc_in = 1'b0;
    step(10);
    chk("R6", "oc with low-side off: pwm drops", pwm_falls - f0, 0);
    @(negedge clk) begin lo_on_in = 1'b1; oc_in = 1'b1; end
    @(negedge clk) oc_in = 1'b0;
    step(10);
    @(negedge clk) lo_on_in = 1'b0;
    chk("R6", "single-sample oc: pwm drops", pwm_falls - f0, 0);
    chk("R6", "ss_code kept after ignored oc", ss_code, REF);
  endtask

  task automatic fault(input logic use_uv);
    @(negedge clk) begin
      if (use_uv) fbuv_in = 1'b1;
      else begin lo_on_in = 1'b1; oc_in = 1'b1; end
    end
    step(5);
    @(negedge clk) begin fbuv_in = 1'b0; oc_in = 1'b0; lo_on_in = 1'b0; end
  endtask

  task automatic t_hiccups();
    int d;
    fork fault(1'b0); measure_low(d); join
    chk("R7", "hiccup 1 pwm low cycles", d, HIC);
    chk("R7", "ss_code restarts at 0", ss_code, 0);
    chk("R7", "no shutdown after hiccup 1", shutdown, 0);
    ticks(7);
    chk("R7", "ramp rises again after hiccup", ss_code, 7);
    fork fault(1'b1); measure_low(d); join
    chk("R8", "undervoltage hiccup pwm low cycles", d, HIC);
    chk("R8", "no shutdown after hiccup 2", shutdown, 0);
    ticks(3);
    chk("R8", "ramp after uv hiccup", ss_code, 3);
  endtask

  task automatic t_latch();
    int r0, ok;
    fault(1'b0);
    step(10);
    chk("R9", "shutdown after third fault", shutdown, 1);
    chk("R9", "pwm_en in shutdown", pwm_en, 0);
    chk("R9", "ss_code in shutdown", ss_code, 0);
    r0 = probe_rises;
    ticks(5);
    step(2 * PER);
    chk("R9", "shutdown held", shutdown, 1);
    chk("R9", "no probing in shutdown", probe_rises - r0, 0);
    @(negedge clk) pgood_in = 1'b0;
    step(6);
    chk("R1", "shutdown cleared by pgood loss", shutdown, 0);
    @(negedge clk) pgood_in = 1'b1;
    wait_probe_rise(ok);
    chk("R9", "probing restarts after pgood return", ok, 1);
  endtask

  task automatic t_pgood_drop();
    int ok;
    wait_probe_rise(ok);
    @(negedge clk) sw_hi_in = 1'b1;
    step(3);
    sw_hi_in = 1'b0;
    step(12);
    chk("R3", "confirm inside one probe pulse", pwm_en, 1);
    ticks(10);
    chk("R4", "ramp before pgood drop", ss_code, 10);
    @(negedge clk) pgood_in = 1'b0;
    step(6);
    chk("R1", "pwm_en after pgood drop", pwm_en, 0);
    chk("R1", "ss_code after pgood drop", ss_code, 0);
    chk("R1", "probe_req after pgood drop", probe_req, 0);
  endtask

  initial begin
    t_reset();
    t_probe();
    t_presence();
    t_softstart();
    t_oc_rejected();
    t_hiccups();
    t_latch();
    t_pgood_drop();
    chk("R10", "cycles with pwm_en and probe_req both high", overlap, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule